// File: doc/BRIEF.md
# Interlaced Two-Level Cache Tuning Sequencer

This controller searches for a low-energy setting of a configurable two-level cache hierarchy. It owns two configuration words, one for the instruction-side hierarchy and one for the data-side hierarchy. Each word holds six fields: first-level size, line length and ways, and second-level size, line length and ways. After a start pulse it changes one field at a time and presents each candidate setting to the cache. It then waits for the energy figure of that trial to arrive on a valid/ready input.

The search tries the parameter with the largest energy effect first. The two cache levels take turns: first-level size, second-level size, first-level line, second-level line, first-level ways, second-level ways. Each field is swept upward from its smallest legal value. The best value found is locked in before the next field is tried. The instruction side is tuned completely, and then the same six steps run for the data side. A one-cycle done pulse marks the end, and both words then hold the chosen settings.

Top module: `cache_tune_seq`

## Requirements
- R1: After reset, and again after each start, both configuration words equal the base setting 12'h9A6 (first level 8 KB, 32 B line, 4 ways; second level 64 KB, 64 B line, 4 ways). Outside a search, energy_ready_o and done_o are low.
- R2: A configuration word packs six 2-bit indices with value 0, 1 or 2. The fields are: [11:10] first-level size (2/4/8 KB), [9:8] first-level line (16/32/64 B), [7:6] first-level ways (1/2/4), [5:4] second-level size (16/32/64 KB), [3:2] second-level line (32/64/128 B) and [1:0] second-level ways (1/2/4).
- R3: The steps run in the order [11:10], [5:4], [9:8], [3:2], [7:6], [1:0], first with tune_side_o low on icfg_o and then with tune_side_o high on dcfg_o. While the instruction side is being tuned, dcfg_o stays at the base setting.
- R4: Within a step, candidates are presented in rising index order from 0. Every other field keeps its committed value.
- R5: A candidate whose ways index exceeds its size index at either level is illegal. It is skipped, and energy_ready_o is never raised for it.
- R6: A step ends when a measured energy is strictly greater than the best energy of that step, or after index 2 has been tried. An equal energy does not end the step and does not replace the earlier best.
- R7: When a step ends, the field is committed to the index that gave the lowest energy in that step. The earliest index wins a tie.
- R8: While energy_ready_o is high and energy_valid_i is low, the presented configuration and energy_ready_o stay unchanged. Each accepted energy word ends exactly one trial.
- R9: done_o is high for exactly one cycle after the last data-side step. From then until the next start, both configuration words hold their final values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a tuning pass (taken while idle) |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| tune_side_o | output | 1 | 0: instruction side under trial, 1: data side |
| icfg_o | output | 12 | Instruction-side configuration word |
| dcfg_o | output | 12 | Data-side configuration word |
| energy_i | input | 32 | Unsigned energy of the current trial |
| energy_valid_i | input | 1 | Energy word valid |
| energy_ready_o | output | 1 | Trial presented, waiting for its energy |

## Verification
The bench checks every presented trial, in order, against an independently built list. A design that swept in the wrong order, or finished one level before starting the other, would fail at the first trial that differs. Three directed energy profiles are used. With flat energy, a design that let a tie replace the best or end the sweep would end with the wrong fields and the wrong trial count. With falling energy, a design that stopped early would miss the largest indices. With rising energy, a design that ignored the stop rule would issue extra trials. The bench also confirms that illegal size/ways pairs never reach the measurement handshake. Seeded random profiles with frequent ties exercise the mixed cases, and the bench checks that the result is held after the done pulse.

// File: rtl/cts_pkg.sv
package cts_pkg;

    localparam int IDX_W   = 2;
    localparam int N_VAL   = 3;
    localparam int N_FIELD = 6;
    localparam int N_STEP  = 6;
    localparam int N_SIDE  = 2;
    localparam int CFG_W   = IDX_W * N_FIELD;
    localparam int STEP_W  = $clog2(N_STEP);

    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t IDX_MAX = idx_t'(N_VAL - 1);

    typedef struct packed {
        idx_t a_size;
        idx_t a_line;
        idx_t a_ways;
        idx_t b_size;
        idx_t b_line;
        idx_t b_ways;
    } cfg_t;

    typedef enum logic [2:0] {
        F_A_SIZE, F_A_LINE, F_A_WAYS, F_B_SIZE, F_B_LINE, F_B_WAYS
    } field_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_CHECK, ST_MEAS, ST_NEXT, ST_DONE
    } state_e;

    localparam cfg_t CFG_BASE = '{
        a_size: idx_t'(2), a_line: idx_t'(1), a_ways: idx_t'(2),
        b_size: idx_t'(2), b_line: idx_t'(1), b_ways: idx_t'(2)
    };

    // Impact order, alternating between the two levels.
    function automatic field_e step_field(input logic [STEP_W-1:0] step);
        case (step)
            3'd0:    return F_A_SIZE;
            3'd1:    return F_B_SIZE;
            3'd2:    return F_A_LINE;
            3'd3:    return F_B_LINE;
            3'd4:    return F_A_WAYS;
            default: return F_B_WAYS;
        endcase
    endfunction

    function automatic cfg_t cfg_set(input cfg_t c, input field_e f, input idx_t v);
        cfg_t r;
        r = c;
        case (f)
            F_A_SIZE: r.a_size = v;
            F_A_LINE: r.a_line = v;
            F_A_WAYS: r.a_ways = v;
            F_B_SIZE: r.b_size = v;
            F_B_LINE: r.b_line = v;
            default:  r.b_ways = v;
        endcase
        return r;
    endfunction

    function automatic logic idx_ok(input idx_t v);
        return v <= IDX_MAX;
    endfunction

    // Ways may not outgrow size at either level.
    function automatic logic cfg_legal(input cfg_t c);
        logic in_range;
        in_range = idx_ok(c.a_size) && idx_ok(c.a_line) && idx_ok(c.a_ways)
                && idx_ok(c.b_size) && idx_ok(c.b_line) && idx_ok(c.b_ways);
        return in_range && (c.a_ways <= c.a_size) && (c.b_ways <= c.b_size);
    endfunction

endpackage

// File: rtl/cts_ctrl.sv
module cts_ctrl
    import cts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              trial_legal_i,
    input  logic              energy_take_i,
    input  logic              best_stop_i,
    output logic              side_o,
    output logic [STEP_W-1:0] step_o,
    output idx_t              cand_o,
    output logic              trial_act_o,
    output logic              meas_o,
    output logic              clr_best_o,
    output logic              commit_o,
    output logic              load_base_o,
    output logic              done_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEP - 1);

    state_e            state_q;
    logic              side_q;
    logic [STEP_W-1:0] step_q;
    idx_t              cand_q;
    logic              step_end;

    assign step_end    = (state_q == ST_NEXT) && (best_stop_i || (cand_q == IDX_MAX));
    assign commit_o    = step_end;
    assign load_base_o = (state_q == ST_IDLE) && start_i;
    assign clr_best_o  = (state_q == ST_LOAD);
    assign meas_o      = (state_q == ST_MEAS);
    assign trial_act_o = (state_q == ST_CHECK) || (state_q == ST_MEAS) || (state_q == ST_NEXT);
    assign done_o      = (state_q == ST_DONE);
    assign side_o      = side_q;
    assign step_o      = step_q;
    assign cand_o      = cand_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            side_q  <= 1'b0;
            step_q  <= '0;
            cand_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        side_q  <= 1'b0;
                        step_q  <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cand_q  <= '0;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    state_q <= trial_legal_i ? ST_MEAS : ST_NEXT;
                end
                ST_MEAS: begin
                    if (energy_take_i) state_q <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (step_end) begin
                        if (step_q == LAST_STEP) begin
                            if (side_q) begin
                                state_q <= ST_DONE;
                            end else begin
                                side_q  <= 1'b1;
                                step_q  <= '0;
                                state_q <= ST_LOAD;
                            end
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end else begin
                        cand_q  <= cand_q + 1'b1;
                        state_q <= ST_CHECK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cts_best.sv
module cts_best
    import cts_pkg::*;
#(
    parameter int E_W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic           take_i,
    input  logic [E_W-1:0] energy_i,
    input  idx_t           cand_i,
    output idx_t           best_idx_o,
    output logic           stop_o
);

    logic           have_q;
    logic [E_W-1:0] best_q;
    idx_t           idx_q;
    logic           stop_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            have_q <= 1'b0;
            best_q <= '0;
            idx_q  <= '0;
            stop_q <= 1'b0;
        end else if (take_i) begin
            if (!have_q || (energy_i < best_q)) begin
                have_q <= 1'b1;
                best_q <= energy_i;
                idx_q  <= cand_i;
                stop_q <= 1'b0;
            end else begin
                stop_q <= (energy_i > best_q);
            end
        end
    end

    assign best_idx_o = idx_q;
    assign stop_o     = stop_q;

endmodule

// File: rtl/cts_overlay.sv
module cts_overlay
    import cts_pkg::*;
(
    input  cfg_t   base_i,
    input  logic   active_i,
    input  field_e field_i,
    input  idx_t   cand_i,
    output cfg_t   cfg_o
);

    assign cfg_o = active_i ? cfg_set(base_i, field_i, cand_i) : base_i;

endmodule

// File: rtl/cache_tune_seq.sv
module cache_tune_seq
    import cts_pkg::*;
#(
    parameter int E_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             done_o,
    output logic             tune_side_o,
    output logic [CFG_W-1:0] icfg_o,
    output logic [CFG_W-1:0] dcfg_o,
    input  logic [E_W-1:0]   energy_i,
    input  logic             energy_valid_i,
    output logic             energy_ready_o
);

    logic              side;
    logic [STEP_W-1:0] step;
    idx_t              cand;
    logic              trial_act;
    logic              meas;
    logic              clr_best;
    logic              commit;
    logic              load_base;
    logic              best_stop;
    idx_t              best_idx;
    logic              take;
    logic              trial_legal;
    field_e            fld;
    cfg_t              view [N_SIDE];

    assign fld         = step_field(step);
    assign take        = meas && energy_valid_i;
    assign trial_legal = cfg_legal(view[side]);

    cts_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .trial_legal_i (trial_legal),
        .energy_take_i (take),
        .best_stop_i   (best_stop),
        .side_o        (side),
        .step_o        (step),
        .cand_o        (cand),
        .trial_act_o   (trial_act),
        .meas_o        (meas),
        .clr_best_o    (clr_best),
        .commit_o      (commit),
        .load_base_o   (load_base),
        .done_o        (done_o)
    );

    cts_best #(.E_W(E_W)) u_best (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr_best),
        .take_i     (take),
        .energy_i   (energy_i),
        .cand_i     (cand),
        .best_idx_o (best_idx),
        .stop_o     (best_stop)
    );

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        cfg_t cfg_q;

        always_ff @(posedge clk) begin
            if (rst || load_base) begin
                cfg_q <= CFG_BASE;
            end else if (commit && (side == 1'(g))) begin
                cfg_q <= cfg_set(cfg_q, fld, best_idx);
            end
        end

        cts_overlay u_ovl (
            .base_i   (cfg_q),
            .active_i (trial_act && (side == 1'(g))),
            .field_i  (fld),
            .cand_i   (cand),
            .cfg_o    (view[g])
        );
    end

    assign icfg_o         = view[0];
    assign dcfg_o         = view[1];
    assign tune_side_o    = side;
    assign energy_ready_o = meas;

endmodule

// File: rtl/cts_checks.sv
module cts_checks
    import cts_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             done_o,
    input logic             tune_side_o,
    input logic [CFG_W-1:0] icfg_o,
    input logic [CFG_W-1:0] dcfg_o,
    input logic             energy_valid_i,
    input logic             energy_ready_o
);

    logic [CFG_W-1:0] act_cfg;
    assign act_cfg = tune_side_o ? dcfg_o : icfg_o;

    AST_RDY_LEGAL: assert property (@(posedge clk) disable iff (rst)
        energy_ready_o |-> cfg_legal(cfg_t'(act_cfg)));  // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (energy_ready_o && !energy_valid_i) |=> (energy_ready_o && $stable(icfg_o) && $stable(dcfg_o) && $stable(tune_side_o)));  // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !energy_ready_o);  // R9

    AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        done_o |=> ($stable(icfg_o) && $stable(dcfg_o)));  // R9

    AST_DSIDE_BASE: assert property (@(posedge clk) disable iff (rst)
        (energy_ready_o && !tune_side_o) |-> (dcfg_o == CFG_W'(CFG_BASE)));  // R3

endmodule

bind cache_tune_seq cts_checks u_chk (
    .clk            (clk),
    .rst            (rst),
    .done_o         (done_o),
    .tune_side_o    (tune_side_o),
    .icfg_o         (icfg_o),
    .dcfg_o         (dcfg_o),
    .energy_valid_i (energy_valid_i),
    .energy_ready_o (energy_ready_o)
);

// File: tb/cache_tune_seq_bench.sv
module cache_tune_seq_bench;

    localparam logic [11:0] BASE = 12'h9A6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        done_o;
    logic        tune_side_o;
    logic [11:0] icfg_o;
    logic [11:0] dcfg_o;
    logic [31:0] energy_i = '0;
    logic        energy_valid_i = 1'b0;
    logic        energy_ready_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    int          mode = 0;
    logic [31:0] salt = '0;
    logic [12:0] exp_trial [0:63];
    int          exp_n = 0;
    logic [11:0] exp_fin [0:1];
    int          got_n = 0;

    always #2 clk = ~clk;

    cache_tune_seq u_cache_tune_seq (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .done_o         (done_o),
        .tune_side_o    (tune_side_o),
        .icfg_o         (icfg_o),
        .dcfg_o         (dcfg_o),
        .energy_i       (energy_i),
        .energy_valid_i (energy_valid_i),
        .energy_ready_o (energy_ready_o)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] fget(input logic [11:0] c, input int f);
        return 2'(c >> (2 * (5 - f)));
    endfunction

    function automatic logic [11:0] fput(input logic [11:0] c, input int f, input logic [1:0] v);
        int s;
        s = 2 * (5 - f);
        return (c & ~(12'h3 << s)) | (12'(v) << s);
    endfunction

    function automatic logic legal(input logic [11:0] c);
        return (fget(c, 2) <= fget(c, 0)) && (fget(c, 5) <= fget(c, 3));
    endfunction

    function automatic logic [31:0] efn(input logic side, input logic [11:0] c);
        logic [31:0] h;
        int sum;
        sum = 0;
        for (int f = 0; f < 6; f++) sum += int'(fget(c, f));
        case (mode)
            0: return 32'd7;
            1: return 32'(100 - sum);
            2: return 32'(10 + sum);
            default: begin
                h = {20'b0, c} * 32'h9E3779B1 ^ (side ? 32'h85EBCA77 : 32'h0) ^ salt;
                h = h ^ (h >> 13);
                h = h * 32'hC2B2AE35;
                h = h ^ (h >> 16);
                return h & 32'h1F;
            end
        endcase
    endfunction

    // Field numbering: 0 L1 size, 1 L1 line, 2 L1 ways, 3 L2 size, 4 L2 line, 5 L2 ways.
    task automatic build_expect();
        int order [6] = '{0, 3, 1, 4, 2, 5};
        logic [11:0] cur, t;
        logic [31:0] e, best;
        logic [1:0]  bv;
        logic        have;
        exp_n = 0;
        for (int s = 0; s < 2; s++) begin
            cur = BASE;
            for (int st = 0; st < 6; st++) begin
                have = 1'b0;
                best = '0;
                bv = fget(cur, order[st]);
                for (int c = 0; c < 3; c++) begin
                    t = fput(cur, order[st], 2'(c));
                    if (legal(t)) begin
                        e = efn(1'(s), t);
                        exp_trial[exp_n] = {1'(s), t};
                        exp_n++;
                        if (!have || e < best) begin
                            have = 1'b1;
                            best = e;
                            bv = 2'(c);
                        end else if (e > best) begin
                            break;
                        end
                    end
                end
                cur = fput(cur, order[st], bv);
            end
            exp_fin[s] = cur;
        end
    endtask

    // Energy responder with random latency.
    initial begin
        int          wait_n;
        logic [12:0] seen;
        wait_n = 0;
        forever begin
            @(negedge clk);
            if (energy_valid_i) begin
                energy_valid_i = 1'b0;
            end else if (energy_ready_o) begin
                seen = {tune_side_o, tune_side_o ? dcfg_o : icfg_o};
                if (wait_n > 0) begin
                    wait_n--;
                end else begin
                    check(legal(seen[11:0]), "R5 legal trial", 32'(seen), 32'(seen));
                    if (got_n < exp_n)
                        check(seen == exp_trial[got_n], "R4 trial order", 32'(seen), 32'(exp_trial[got_n]));
                    else
                        check(1'b0, "R6 extra trial", 32'(got_n), 32'(exp_n));
                    if (!tune_side_o)
                        check(dcfg_o == BASE, "R3 data side idle", 32'(dcfg_o), 32'(BASE));
                    got_n++;
                    energy_i       = efn(seen[12], seen[11:0]);
                    energy_valid_i = 1'b1;
                    wait_n         = int'($urandom % 3);
                end
            end
        end
    end

    // Checks that the word stays put while waiting (R8).
    initial begin
        logic [11:0] hold;
        forever begin
            @(negedge clk);
            if (energy_ready_o && !energy_valid_i) begin
                hold = tune_side_o ? dcfg_o : icfg_o;
                @(negedge clk);
                if (energy_ready_o)
                    check(hold == (tune_side_o ? dcfg_o : icfg_o), "R8 hold while waiting",
                          32'(tune_side_o ? dcfg_o : icfg_o), 32'(hold));
            end
        end
    end

    task automatic run_case(input int m, input logic [31:0] sd, input logic [11:0] fixed_i, input logic use_fixed);
        int n;
        mode = m;
        salt = sd;
        build_expect();
        got_n = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(icfg_o == BASE, "R1 base after start", 32'(icfg_o), 32'(BASE));
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done_o == 1'b1, "R9 done reached", 32'(done_o), 32'd1);
        check(icfg_o == exp_fin[0], "R7 instruction result", 32'(icfg_o), 32'(exp_fin[0]));
        check(dcfg_o == exp_fin[1], "R7 data result", 32'(dcfg_o), 32'(exp_fin[1]));
        check(got_n == exp_n, "R6 trial count", 32'(got_n), 32'(exp_n));
        if (use_fixed) begin
            check(icfg_o == fixed_i, "R6 directed instruction result", 32'(icfg_o), 32'(fixed_i));
            check(dcfg_o == fixed_i, "R6 directed data result", 32'(dcfg_o), 32'(fixed_i));
        end
        @(negedge clk);
        check(done_o == 1'b0, "R9 done single cycle", 32'(done_o), 32'd0);
        check(energy_ready_o == 1'b0, "R9 quiet after done", 32'(energy_ready_o), 32'd0);
        repeat (3) @(negedge clk);
        check(icfg_o == exp_fin[0] && dcfg_o == exp_fin[1], "R9 result held",
              32'({icfg_o, dcfg_o}), 32'({exp_fin[0], exp_fin[1]}));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(icfg_o == BASE, "R1 reset instruction word", 32'(icfg_o), 32'(BASE));
        check(dcfg_o == BASE, "R1 reset data word", 32'(dcfg_o), 32'(BASE));
        check(!done_o && !energy_ready_o, "R1 reset outputs", 32'({done_o, energy_ready_o}), 32'd0);
        check(fget(BASE, 0) == 2'd2 && fget(BASE, 4) == 2'd1, "R2 field layout", 32'(BASE), 32'h9A6);
        // Flat energy: ties keep the smallest legal index (R6).
        run_case(0, 32'h0, 12'h820, 1'b1);
        // Falling energy: every sweep reaches index 2 (R4).
        run_case(1, 32'h0, 12'hAAA, 1'b1);
        // Rising energy: sweeps stop at the second measurement (R6).
        run_case(2, 32'h0, 12'h0, 1'b0);
        for (int k = 0; k < 6; k++) run_case(3, $urandom, 12'h0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule